// File: doc/BRIEF.md
# Sync Event Strobe Combiner

This block produces the single sync-event strobe that starts a timing engine's frame sequence. Three sources can raise it: a free-running internal generator whose period is counted in interface-clock cycles, an external sync pin, and a one-shot request from control logic. Each source has its own enable. When several sources fire in the same cycle, their hits are ORed and the block emits one strobe that lasts one cycle.

The internal period is a 64-bit quantity. It is loaded as two 32-bit words through word write strobes. Only the low `CNT_W` bits are kept, because the counter width is set at build time. When `EXT_SYNC_EN` is set, the external pin passes through a `SYNC_STAGES`-deep synchronizer before its rising edge is detected. Otherwise the pin is taken directly.

Top module: `sync_trigger_gen`

## Requirements
- R1: While reset is applied and after it is released, `sync_o` is low and the stored period is zero, so no strobe appears until a source is configured.
- R2: `period_lo_we` loads bits 31:0 of the period from `period_wdata`, and `period_hi_we` loads bits 63:32. Bits at position `CNT_W` and above are discarded.
- R3: With `int_en_i` high and a non-zero period P, `sync_o` is high for one cycle every P cycles. The first strobe appears P clock edges after the edge that first samples the enable. With P = 1, the strobe is high on every cycle.
- R4: With `int_en_i` low, or with a period of zero, the internal source never fires. The internal count restarts from zero each time the source is enabled again.
- R5: With `ext_en_i` high, a low-to-high transition of `ext_sync_i` gives one strobe `SYNC_STAGES`+1 edges after the first edge that samples the high level. A level that stays high gives no further strobes.
- R6: With `ext_en_i` low, transitions of `ext_sync_i` are ignored. A pin that is already high when the enable is set does not produce a strobe.
- R7: A rising edge of `soft_req_i` gives exactly one strobe, two edges after the edge that samples it. Holding the request high gives no further strobes, because the pending pulse clears itself after one cycle.
- R8: Hits from different sources that land in the same cycle give a single one-cycle strobe, not several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_sync_i | input | 1 | External sync pin |
| int_en_i | input | 1 | Enable for the internal periodic source |
| ext_en_i | input | 1 | Enable for the external source |
| soft_req_i | input | 1 | Software request; a rising edge asks for one pulse |
| period_lo_we | input | 1 | Write strobe for period bits 31:0 |
| period_hi_we | input | 1 | Write strobe for period bits 63:32 |
| period_wdata | input | 32 | Period word data |
| sync_o | output | 1 | One-cycle sync-event strobe |

## Verification
Each source has a fixed latency to the registered strobe:
- Internal source: the strobe appears P edges after the enable is sampled.
- Software request: the strobe appears two edges after the request is sampled.
- External pin: the strobe appears `SYNC_STAGES`+1 edges after the pin is sampled high, which is three edges in the bench configuration.

The bench drives inputs just after a falling edge and samples `sync_o` after every falling edge. It checks every cycle in a window against the expected edge count. This catches strobes that arrive early, arrive late, or are repeated.

The coincidence test times the three sources so that they all land on the same edge. It then checks that the strobe is high on exactly that edge and low on both neighbouring edges.

// File: rtl/stg_pkg.sv
package stg_pkg;
  // Strobe sources, used as bit positions in the hit vector
  typedef enum int unsigned {
    SRC_INT  = 0,
    SRC_EXT  = 1,
    SRC_SOFT = 2
  } stg_src_e;

  localparam int unsigned SRC_N = 3;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PERIOD_MAX_W = 64;
endpackage

// File: rtl/stg_period_gen.sv
module stg_period_gen
  import stg_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]        per_q, per_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [PERIOD_MAX_W-1:0] merged;
  logic                    active;

  // Period storage: only CNT_W bits are kept, which masks the upper word
  always_comb begin
    merged = PERIOD_MAX_W'(per_q);
    if (lo_we_i) merged[WORD_W-1:0] = wdata_i;
    if (hi_we_i) merged[PERIOD_MAX_W-1:WORD_W] = wdata_i;
    per_d = merged[CNT_W-1:0];
  end

  assign active = en_i && (per_q != '0);
  assign hit_o  = active && (cnt_q >= (per_q - ONE));

  always_comb begin
    if (!active)    cnt_d = '0;
    else if (hit_o) cnt_d = '0;
    else            cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
    end
  end

  // R4: an idle generator restarts its count from zero
  p_idle_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0));

  // R4: a zero period never fires
  p_zero_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0) |-> !hit_o);
endmodule

// File: rtl/stg_ext_detect.sv
module stg_ext_detect #(
  parameter bit          SYNC_EN     = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic en_i,
  output logic hit_o
);
  logic cur;
  logic prev_q;

  generate
    if (SYNC_EN) begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q, chain_d;
      always_comb begin
        chain_d[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) chain_d[i] = chain_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign cur = chain_q[SYNC_STAGES-1];
    end else begin : g_direct
      assign cur = pin_i;
    end
  endgenerate

  // Edge memory tracks the level even while disabled, so a level that is
  // already high when the enable is set does not fire
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign hit_o = en_i && cur && !prev_q;

  // R5: an edge gives a hit on one cycle only
  p_ext_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
endmodule

// File: rtl/stg_soft_pulse.sv
module stg_soft_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pend_o
);
  logic req_last_q;
  logic pend_q, pend_d;

  // Accept only a new request; the pending bit clears itself one cycle later
  always_comb pend_d = req_i && !req_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_last_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      req_last_q <= req_i;
      pend_q     <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R7: a pending pulse never lasts more than one cycle
  p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);
endmodule

// File: rtl/sync_trigger_gen.sv
module sync_trigger_gen
  import stg_pkg::*;
#(
  parameter int unsigned CNT_W       = 64,
  parameter bit          EXT_SYNC_EN = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_sync_i,
  input  logic        int_en_i,
  input  logic        ext_en_i,
  input  logic        soft_req_i,
  input  logic        period_lo_we,
  input  logic        period_hi_we,
  input  logic [31:0] period_wdata,
  output logic        sync_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [SRC_N-1:0] src_hit;
  logic             sync_q, sync_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  stg_period_gen #(.CNT_W(CNT_W)) u_int (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en_i    (int_en_i),
    .lo_we_i (period_lo_we),
    .hi_we_i (period_hi_we),
    .wdata_i (period_wdata),
    .hit_o   (src_hit[SRC_INT])
  );

  stg_ext_detect #(.SYNC_EN(EXT_SYNC_EN), .SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk   (clk),
    .rst_n (rst_n_int),
    .pin_i (ext_sync_i),
    .en_i  (ext_en_i),
    .hit_o (src_hit[SRC_EXT])
  );

  stg_soft_pulse u_soft (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .req_i  (soft_req_i),
    .pend_o (src_hit[SRC_SOFT])
  );

  // Coincident hits merge into one strobe
  always_comb sync_d = |src_hit;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sync_q <= 1'b0;
    else            sync_q <= sync_d;
  end

  assign sync_o = sync_q;

  // R1: with every source quiet the strobe stays low
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!int_en_i && !ext_en_i && !src_hit[SRC_SOFT]) |=> !sync_o);
endmodule

// File: tb/sync_trigger_gen_test.sv
`timescale 1ns/1ps
module sync_trigger_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_sync_i, int_en_i, ext_en_i, soft_req_i;
  logic        period_lo_we, period_hi_we;
  logic [31:0] period_wdata;
  logic        sync_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sync_trigger_gen #(.CNT_W(36), .EXT_SYNC_EN(1'b1), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .ext_sync_i(ext_sync_i), .int_en_i(int_en_i),
    .ext_en_i(ext_en_i), .soft_req_i(soft_req_i), .period_lo_we(period_lo_we),
    .period_hi_we(period_hi_we), .period_wdata(period_wdata), .sync_o(sync_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: sync_o=%b expected %b", req, k, act, exp);
    end
  endtask

  // Watch n edges; strobes expected at edge first, first+gap, ... (gap 0: single)
  task automatic watch(input int n, input int first, input int gap, input string req);
    for (int k = 1; k <= n; k++) begin
      logic e;
      step();
      e = 1'b0;
      if (first > 0 && k >= first) begin
        if (gap == 0) e = (k == first);
        else          e = ((k - first) % gap) == 0;
      end
      chk(sync_o, e, req, k);
    end
  endtask

  task automatic wr_word(input bit hi, input logic [31:0] v);
    period_wdata = v;
    if (hi) period_hi_we = 1'b1; else period_lo_we = 1'b1;
    step();
    period_lo_we = 1'b0;
    period_hi_we = 1'b0;
  endtask

  task automatic settle();
    int_en_i = 1'b0; ext_en_i = 1'b0; soft_req_i = 1'b0; ext_sync_i = 1'b0;
    repeat (6) step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(sync_o, 1'b0, "R1 in reset", 0);
    rst_n = 1'b1;
    repeat (4) step();
    int_en_i = 1'b1;           // period still zero from reset
    watch(12, 0, 0, "R1 after reset");
    settle();
  endtask

  task automatic t_internal(input int p, input string req);
    wr_word(1'b0, 32'(p));
    int_en_i = 1'b1;
    watch(3 * p + 2, p, p, req);
    settle();
  endtask

  task automatic t_mask();
    wr_word(1'b0, 32'd6);
    wr_word(1'b1, 32'h10);     // bit 36 lies above CNT_W=36
    int_en_i = 1'b1;
    watch(20, 6, 6, "R2 mask");
    settle();
    wr_word(1'b1, 32'h0);
  endtask

  task automatic t_disable();
    wr_word(1'b0, 32'd5);
    int_en_i = 1'b1;
    watch(7, 5, 5, "R4 before pause");
    int_en_i = 1'b0;
    watch(8, 0, 0, "R4 disabled");
    int_en_i = 1'b1;
    watch(12, 5, 5, "R4 restart");
    settle();
    wr_word(1'b0, 32'd0);
    int_en_i = 1'b1;
    watch(12, 0, 0, "R4 zero period");
    settle();
  endtask

  task automatic t_ext();
    ext_en_i = 1'b1;
    step();
    ext_sync_i = 1'b1;
    watch(10, 3, 0, "R5 edge");
    ext_sync_i = 1'b0;
    repeat (4) step();
    ext_sync_i = 1'b1;
    step(); ext_sync_i = 1'b0;  // one-cycle pulse on the pin
    watch(6, 2, 0, "R5 short pulse");
    settle();
  endtask

  task automatic t_ext_off();
    ext_sync_i = 1'b1;
    watch(6, 0, 0, "R6 disabled edge");
    ext_en_i = 1'b1;           // pin already high
    watch(6, 0, 0, "R6 level at enable");
    settle();
  endtask

  task automatic t_soft();
    soft_req_i = 1'b1;
    step(); soft_req_i = 1'b0;
    watch(5, 1, 0, "R7 pulse");
    soft_req_i = 1'b1;         // held high
    watch(8, 2, 0, "R7 held");
    settle();
  endtask

  task automatic t_coincide();
    wr_word(1'b0, 32'd4);
    ext_en_i = 1'b1;
    int_en_i = 1'b1;
    step(); chk(sync_o, 1'b0, "R8", 1);
    ext_sync_i = 1'b1;
    step(); chk(sync_o, 1'b0, "R8", 2);
    soft_req_i = 1'b1;
    step(); chk(sync_o, 1'b0, "R8", 3);
    soft_req_i = 1'b0;
    step(); chk(sync_o, 1'b1, "R8 merged", 4);
    step(); chk(sync_o, 1'b0, "R8 single", 5);
    step(); chk(sync_o, 1'b0, "R8", 6);
    step(); chk(sync_o, 1'b0, "R8", 7);
    step(); chk(sync_o, 1'b1, "R8 next internal", 8);
    settle();
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ext_sync_i = 1'b0; int_en_i = 1'b0; ext_en_i = 1'b0; soft_req_i = 1'b0;
    period_lo_we = 1'b0; period_hi_we = 1'b0; period_wdata = '0;
    t_reset();
    t_internal(5, "R3 period 5");
    t_internal(1, "R3 period 1");
    t_internal(7, "R2 low word");
    t_mask();
    t_disable();
    t_ext();
    t_ext_off();
    t_soft();
    t_coincide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule